// File: doc/BRIEF.md
# Row Write Latch Buffer

This block collects program words ahead of a nonvolatile row write. Each load presents an address and a 14-bit word. The word goes into one of 32 latch slots, and the low five address bits pick the slot. A slot is written again whenever a later load maps to it, so loading more than a row's worth of words simply replaces older entries.

A commit strobe carries an address. The row that contains that address is the target. The block then streams the whole 32-word row toward the memory as address/data writes over a valid/ready handshake, in ascending address order. Slots that were not loaded since the previous commit are sent as the erased value. The target locations are not erased first.

A commit that follows no load is refused: it raises a one-cycle error flag and starts no writes. While a row is being streamed the block accepts neither loads nor commits. After the last word of the row is accepted, every slot returns to the not-loaded state.

Top module: `row_write_latch`

## Requirements
- R1: The buffer holds 32 words of 14 bits. A load with `ld_valid` high writes `ld_data` into slot `ld_addr[4:0]`. The upper address bits of a load have no effect.
- R2: A commit with at least one slot loaded emits exactly 32 writes. Write i (i = 0..31) carries address `{commit_addr[13:5], i}`. The words leave in ascending order, one per cycle in which `wr_valid` and `wr_ready` are both high.
- R3: The target row is taken from `commit_addr` at commit time. If loads at 0002h..0021h are committed with 0021h, they land at 0020h..003Fh. For example, address 0022h receives the word that was loaded at 0002h.
- R4: A second load to the same slot before a commit replaces the first. A run of more than 32 consecutive loads keeps only the last word for each slot.
- R5: A slot not loaded since the last completed row write is emitted as 3FFFh.
- R6: A commit while idle with no slot loaded starts no writes. `commit_err` is then high for exactly the one cycle after the commit edge.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R8: While a row is being streamed, loads and commits are ignored. A load presented in the same cycle as an accepted commit is also ignored.
- R9: After the 32nd write is accepted, all slots count as not loaded. A following commit reports an error, and stale data is emitted as 3FFFh.
- R10: After reset, `wr_valid` and `commit_err` are low and no slot counts as loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load strobe |
| ld_addr | input | 14 | Load address; bits 4:0 select the slot |
| ld_data | input | 14 | Word to load |
| commit | input | 1 | Begin-programming strobe |
| commit_addr | input | 14 | Current address at commit; bits 13:5 give the row |
| wr_valid | output | 1 | Write stream word valid |
| wr_ready | input | 1 | Write stream accept |
| wr_addr | output | 14 | Memory address of the current write |
| wr_data | output | 14 | Word of the current write |
| commit_err | output | 1 | One-cycle pulse: commit refused because nothing was loaded |

## Verification
The hardest case to reach is a load or commit that arrives while a row is mid-stream and held by back-pressure. If such a load were accepted, it would only show up in a slot the stream has not yet reached. The bench therefore stalls the stream with a ready pattern and, on the third stall cycle, presents both a load to slot 20 and a second commit. It then checks that slot 20 still carries the earlier word and that no second row or error follows. A load in the same cycle as the commit is aimed at a slot that was never loaded, so if it were accepted it would appear in place of 3FFFh.

// File: rtl/rwl_pkg.sv
package rwl_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } rwl_state_e;
endpackage

// File: rtl/rwl_latch_array.sv
module rwl_latch_array #(
  parameter int WORD_W = 14,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic              any_loaded
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [WORD_W-1:0] ERASED = {WORD_W{1'b1}};

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  filled_q, filled_d;

  // storage: no reset, a slot is only read out once its filled bit is set
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_word;
  end

  always_comb begin
    filled_d = filled_q;
    if (clr)   filled_d = '0;
    if (wr_en) filled_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filled_q <= '0;
    else        filled_q <= filled_d;
  end

  assign rd_word    = filled_q[rd_idx] ? mem_q[rd_idx] : ERASED;
  assign any_loaded = |filled_q;

  // R1: a load marks its slot as filled
  a_r1_load_marks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> filled_q[$past(wr_idx)]);
  // R9: completing a row leaves nothing loaded
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !any_loaded);
endmodule

// File: rtl/rwl_stream_ctrl.sv
module rwl_stream_ctrl
  import rwl_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [ROW_W-1:0] commit_row,
  input  logic             any_loaded,
  input  logic             out_ready,
  output logic             busy,
  output logic [ROW_W-1:0] row,
  output logic [IDX_W-1:0] idx,
  output logic             clr,
  output logic             err
);
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  rwl_state_e       state_q, state_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             err_q, err_d;

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    idx_d   = idx_q;
    err_d   = 1'b0;
    clr     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (commit) begin
          if (any_loaded) begin
            state_d = ST_SEND;
            row_d   = commit_row;
            idx_d   = '0;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (out_ready) begin
          if (idx_q == LAST_IDX) begin
            state_d = ST_IDLE;
            clr     = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  assign busy = (state_q == ST_SEND);
  assign row  = row_q;
  assign idx  = idx_q;
  assign err  = err_q;

  // R2: each accepted word other than the last advances the slot by one
  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    busy && out_ready && (idx_q != LAST_IDX) |=> busy && (idx_q == IDX_W'($past(idx_q) + 1'b1)));
  // R6: a refused commit never coexists with streaming
  a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy);
endmodule

// File: rtl/row_write_latch.sv
module row_write_latch #(
  parameter int ADDR_W = 14,
  parameter int WORD_W = 14,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_addr,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              commit_err
);
  localparam int ROW_W = ADDR_W - IDX_W;

  logic             busy, clr, any_loaded, ld_en;
  logic [ROW_W-1:0] row;
  logic [IDX_W-1:0] idx;

  // loads only while idle and not colliding with a commit
  assign ld_en = ld_valid && !busy && !commit;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{ld_addr[ADDR_W-1:IDX_W], commit_addr[IDX_W-1:0]};

  rwl_latch_array #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ld_en),
    .wr_idx     (ld_addr[IDX_W-1:0]),
    .wr_word    (ld_data),
    .clr        (clr),
    .rd_idx     (idx),
    .rd_word    (wr_data),
    .any_loaded (any_loaded)
  );

  rwl_stream_ctrl #(.ROW_W(ROW_W), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .commit_row (commit_addr[ADDR_W-1:IDX_W]),
    .any_loaded (any_loaded),
    .out_ready  (wr_ready),
    .busy       (busy),
    .row        (row),
    .idx        (idx),
    .clr        (clr),
    .err        (commit_err)
  );

  assign wr_valid = busy;
  assign wr_addr  = {row, idx};

  // R7: a stalled word is held unchanged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R3: the row stays fixed across consecutive stream cycles
  a_r3_row_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && $past(wr_valid) |-> wr_addr[ADDR_W-1:IDX_W] == $past(wr_addr[ADDR_W-1:IDX_W]));
  // R6: an error pulse is never accompanied by writes
  a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    commit_err |-> !wr_valid);
  // R6: the error flag lasts one cycle
  a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit_err |=> !commit_err);
endmodule

// File: tb/sim_row_write_latch.sv
`timescale 1ns/1ps
module sim_row_write_latch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid, commit, wr_ready;
  logic [13:0] ld_addr, ld_data, commit_addr;
  logic        wr_valid, commit_err;
  logic [13:0] wr_addr, wr_data;

  int checks = 0;
  int errors = 0;
  logic [13:0] exp_data [32];
  logic [31:0] exp_loaded;

  always #2 clk = ~clk;

  row_write_latch u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_data(ld_data),
    .commit(commit), .commit_addr(commit_addr), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .commit_err(commit_err)
  );

  function automatic logic [13:0] fdat(input logic [13:0] a);
    return 14'(a * 14'h1F3 + 14'h055);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic load(input logic [13:0] a, input logic [13:0] d);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
    exp_data[a[4:0]]   = d;
    exp_loaded[a[4:0]] = 1'b1;
  endtask

  // mode 0: always ready, 1: alternating, 2: ready one cycle in four
  task automatic run_stream(input logic [13:0] caddr, input int mode, input bit poke,
                            input bit same_ld, input string req);
    bit expect_rows;
    int n, cyc;
    bit rdy;
    logic [13:0] ea, ed;
    expect_rows = |exp_loaded;
    commit = 1'b1; commit_addr = caddr;
    if (same_ld) begin
      ld_valid = 1'b1; ld_addr = {caddr[13:5], 5'd7}; ld_data = 14'h0ABC;
    end
    @(negedge clk);
    commit = 1'b0; ld_valid = 1'b0;
    if (!expect_rows) begin
      chk(commit_err == 1'b1, {req, " error pulse"}, commit_err, 1);
      chk(wr_valid == 1'b0, {req, " no writes on refused commit"}, wr_valid, 0);
      @(negedge clk);
      chk(commit_err == 1'b0, {req, " error pulse one cycle"}, commit_err, 0);
      chk(wr_valid == 1'b0, {req, " still no writes"}, wr_valid, 0);
      return;
    end
    chk(commit_err == 1'b0, {req, " no error"}, commit_err, 0);
    n = 0; cyc = 0;
    while (n < 32 && cyc < 400) begin
      rdy = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : ((cyc % 4) == 3);
      wr_ready = rdy;
      if (poke && cyc == 2) begin
        // R8: load and commit while the stream is stalled
        ld_valid = 1'b1; ld_addr = {caddr[13:5], 5'd20}; ld_data = 14'h2222;
        commit = 1'b1; commit_addr = 14'h3000;
      end else begin
        ld_valid = 1'b0; commit = 1'b0;
      end
      chk(wr_valid == 1'b1, {req, " valid throughout row"}, wr_valid, 1);
      if (wr_valid && rdy) begin
        ea = {caddr[13:5], 5'(n)};
        ed = exp_loaded[n] ? exp_data[n] : 14'h3FFF;
        chk(wr_addr == ea, {req, " write address"}, wr_addr, ea);
        chk(wr_data == ed, {req, " write data"}, wr_data, ed);
        n++;
      end
      @(negedge clk);
      cyc++;
    end
    ld_valid = 1'b0; commit = 1'b0; wr_ready = 1'b0;
    chk(n == 32, {req, " word count"}, n, 32);
    chk(wr_valid == 1'b0, {req, " idle after row"}, wr_valid, 0);
    repeat (3) @(negedge clk);
    chk(wr_valid == 1'b0 && commit_err == 1'b0, {req, " no trailing activity"}, wr_valid, 0);
    exp_loaded = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_valid = 1'b0; commit = 1'b0; wr_ready = 1'b0;
    ld_addr = '0; ld_data = '0; commit_addr = '0; exp_loaded = '0;
    for (int i = 0; i < 32; i++) exp_data[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(wr_valid == 1'b0, "R10 wr_valid after reset", wr_valid, 0);
    chk(commit_err == 1'b0, "R10 commit_err after reset", commit_err, 0);
    run_stream(14'h0040, 0, 0, 0, "R10/R6 commit after reset");

    // R1/R2: full row with upper load address bits varied
    for (int i = 0; i < 32; i++) load(14'(((i * 7) << 5) | i), fdat(14'(i + 14'h40)));
    run_stream(14'h005F, 0, 0, 0, "R1/R2 full row");

    // R3: loads at 0002h..0021h committed at 0021h land at 0020h..003Fh
    for (int a = 2; a <= 33; a++) load(14'(a), fdat(14'(a)));
    chk(exp_data[2] == fdat(14'h0002), "R3 word for 0022h comes from 0002h", exp_data[2], fdat(14'h0002));
    run_stream(14'h0021, 1, 0, 0, "R3 row from commit address");

    // R4: 40 loads overwrite slots 0..7, committed to top row with back-pressure
    for (int k = 0; k < 40; k++) load(14'(14'h100 + k), fdat(14'(k * 3 + 1)));
    run_stream(14'h3FE7, 2, 0, 0, "R4/R7 overwrite");

    // R9: nothing loaded after completed row
    run_stream(14'h0100, 0, 0, 0, "R9 commit after completed row");

    // R5/R9: sparse row, stale data reads as erased
    load(14'h00A3, 14'h0123);
    load(14'h00B1, 14'h1F1F);
    run_stream(14'h00A0, 0, 0, 0, "R5/R9 sparse row");

    // R8: load and commit during a stalled stream
    for (int i = 0; i < 32; i++) load(14'(14'h0200 + i), fdat(14'(i * 5)));
    run_stream(14'h0200, 2, 1, 0, "R8 busy ignores inputs");

    // R8: load in the commit cycle is dropped (slot 7 stays erased)
    load(14'h0301, 14'h0777);
    run_stream(14'h0300, 1, 0, 1, "R8 same-cycle load");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule